// File: doc/BRIEF.md
# SMT Thread Fetch Selector

This block decides, every clock cycle, which hardware thread of a simultaneously multithreaded core gets the fetch and decode slot. Each thread owns its own program counter and fetch queue, so the one-hot grant simply steers that cycle's fetch to one thread's PC and queue. No context switch is involved: every thread that is running is a candidate in every cycle.

The selector keeps an in-flight instruction count for each thread. The count rises by the number of instructions dispatched into that thread's share of the back-end queues and falls by the number committed or squashed. Among the threads that are running, not stalled and below their static share of the back-end, the grant goes to the one with the smallest count. This steers the front end toward an equal split of back-end resources. Ties are settled by a rotating pointer, so threads with equal counts take turns on successive cycles. When only one thread qualifies, it takes every grant. A thread that has filled its share is skipped, so a slow thread cannot starve the others.

Top module: `smt_fetch_arbiter`

## Requirements
- R1: While reset is applied and until the synchronised reset releases, `grant_valid` is 0 and `grant` is all zeros. After reset, every count is zero and the rotating pointer addresses thread 0.
- R2: A thread whose `thread_active` bit is 0, or whose `thread_stall` bit is 1, is never granted.
- R3: The grant goes to an eligible thread whose in-flight count is the minimum over all eligible threads.
- R4: Among eligible threads that share the minimum count, the winner is the first one met when scanning upward from the pointer and wrapping from thread N-1 to thread 0. After a grant to thread g, the pointer becomes (g+1) mod N.
- R5: When all threads are eligible and no counts change, successive grants visit threads 0, 1, ..., N-1 in order and then wrap.
- R6: When exactly one thread is eligible, that thread is granted in every such cycle.
- R7: A thread whose count equals the per-thread limit (default: queue depth divided by thread count) is not granted.
- R8: Each cycle, a thread's count becomes count + dispatched − retired. Field t of `disp_cnt` and of `retire_cnt` sits at bits [t*DW +: DW]. Both happen in the same cycle, and the result is clamped to the range 0 to the limit.
- R9: When no thread is eligible, `grant_valid` is 0, `grant` is zero and the pointer keeps its value.
- R10: `grant` has at most one bit set, and `grant_valid` is 1 exactly when one bit is set. Bit t of `grant` stands for thread t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| thread_active | input | NUM_THREADS | Thread t is running |
| thread_stall | input | NUM_THREADS | Thread t cannot fetch this cycle (e.g. instruction cache miss) |
| disp_cnt | input | NUM_THREADS*CNT_DW | Per-thread instructions entering the back-end share this cycle |
| retire_cnt | input | NUM_THREADS*CNT_DW | Per-thread instructions committed or squashed this cycle |
| grant | output | NUM_THREADS | One-hot fetch grant |
| grant_valid | output | 1 | A thread was granted this cycle |

## Verification
The bench aims at ties under several pointer positions. A selector that ignores the pointer or moves it wrongly would grant the same low-numbered thread again and again, where a rotating sequence is expected. It drives a dispatch burst past the limit and a retire burst below zero. A counter that wraps rather than clamps would make a full thread look empty, or an empty one look full, and the grant order would then disagree with the model. It also holds a thread exactly at its limit while it is the only candidate, and stalls every thread at once. A design that ignores the quota, or that moves the pointer on an idle cycle, would grant when it should not, or would resume the rotation at the wrong thread.

// File: rtl/smt_fetch_pkg.sv
package smt_fetch_pkg;

  // Saturating in-flight count update: add and subtract in the same cycle,
  // clamp at zero and at the static per-thread limit.
  function automatic logic [31:0] occ_update(input logic [31:0] cur,
                                             input logic [31:0] add,
                                             input logic [31:0] sub,
                                             input logic [31:0] lim);
    logic [31:0] sum;
    logic [31:0] res;
    sum = cur + add;
    if (sub >= sum) res = 32'd0;
    else            res = sum - sub;
    if (res > lim)  res = lim;
    return res;
  endfunction

endpackage

// File: rtl/smt_occ_counter.sv
module smt_occ_counter #(
  parameter int CW    = 5,
  parameter int DW    = 3,
  parameter int LIMIT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] inc,
  input  logic [DW-1:0] dec,
  output logic [CW-1:0] occ,
  output logic          below
);
  import smt_fetch_pkg::*;

  logic [CW-1:0] occ_q;
  logic [CW-1:0] occ_d;
  logic          upd_en;

  always_comb begin
    upd_en = (inc != '0) || (dec != '0);
    occ_d  = CW'(occ_update(32'(occ_q), 32'(inc), 32'(dec), 32'(LIMIT)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (upd_en) occ_q <= occ_d;
  end

  assign occ   = occ_q;
  assign below = (32'(occ_q) < 32'(LIMIT));

endmodule

// File: rtl/smt_min_pick.sv
module smt_min_pick #(
  parameter int N  = 4,
  parameter int CW = 5,
  parameter int TW = 2
) (
  input  logic [N-1:0]    elig,
  input  logic [N*CW-1:0] occ_flat,
  input  logic [TW-1:0]   ptr,
  output logic [N-1:0]    grant,
  output logic            valid,
  output logic [TW-1:0]   gidx
);
  logic [CW-1:0] best;

  // Scan from the pointer upward with wrap; strict less-than keeps the
  // earliest thread in scan order on a tie.
  always_comb begin
    valid = 1'b0;
    best  = '0;
    gidx  = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N) idx = idx - N;
      if (elig[idx] && (!valid || (occ_flat[idx*CW +: CW] < best))) begin
        valid = 1'b1;
        best  = occ_flat[idx*CW +: CW];
        gidx  = TW'(idx);
      end
    end
    grant = '0;
    if (valid) grant[gidx] = 1'b1;
  end

endmodule

// File: rtl/smt_fetch_arbiter.sv
module smt_fetch_arbiter #(
  parameter int NUM_THREADS = 4,
  parameter int QUEUE_DEPTH = 64,
  parameter int OCC_LIMIT   = QUEUE_DEPTH / NUM_THREADS,
  parameter int CNT_DW      = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS-1:0]        thread_active,
  input  logic [NUM_THREADS-1:0]        thread_stall,
  input  logic [NUM_THREADS*CNT_DW-1:0] disp_cnt,
  input  logic [NUM_THREADS*CNT_DW-1:0] retire_cnt,
  output logic [NUM_THREADS-1:0]        grant,
  output logic                          grant_valid
);
  localparam int N  = NUM_THREADS;
  localparam int TW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(OCC_LIMIT + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [N*CW-1:0] occ_flat;
  logic [N-1:0]    below;
  logic [N-1:0]    elig;

  for (genvar t = 0; t < N; t++) begin : g_thr
    smt_occ_counter #(.CW(CW), .DW(CNT_DW), .LIMIT(OCC_LIMIT)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .inc   (disp_cnt[t*CNT_DW +: CNT_DW]),
      .dec   (retire_cnt[t*CNT_DW +: CNT_DW]),
      .occ   (occ_flat[t*CW +: CW]),
      .below (below[t])
    );
  end

  always_comb begin
    elig = thread_active & ~thread_stall & below & {N{rst_sync_n}};
  end

  logic [TW-1:0] rr_ptr;
  logic [TW-1:0] rr_ptr_d;
  logic [TW-1:0] win_idx;
  logic          win_valid;
  logic [N-1:0]  win_grant;

  smt_min_pick #(.N(N), .CW(CW), .TW(TW)) u_pick (
    .elig     (elig),
    .occ_flat (occ_flat),
    .ptr      (rr_ptr),
    .grant    (win_grant),
    .valid    (win_valid),
    .gidx     (win_idx)
  );

  always_comb begin
    if (win_idx == TW'(N - 1)) rr_ptr_d = '0;
    else                       rr_ptr_d = win_idx + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    rr_ptr <= '0;
    else if (win_valid) rr_ptr <= rr_ptr_d;
  end

  assign grant       = win_grant;
  assign grant_valid = win_valid;

endmodule

// File: rtl/smt_fetch_arbiter_chk.sv
module smt_fetch_arbiter_chk #(
  parameter int N     = 4,
  parameter int CW    = 5,
  parameter int TW    = 2,
  parameter int LIMIT = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  active,
  input logic [N-1:0]  stall,
  input logic [N-1:0]  grant,
  input logic          grant_valid,
  input logic [N*CW-1:0] occ_flat,
  input logic [TW-1:0] ptr
);
  logic [N-1:0] room;
  for (genvar i = 0; i < N; i++) begin : g_room
    assign room[i] = 32'(occ_flat[i*CW +: CW]) < 32'(LIMIT);
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (grant_valid == (grant != '0)));

  p_no_idle_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~(active & ~stall)) == '0);

  p_work_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((active & ~stall & room) != '0) |-> grant_valid);

  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |=> $stable(ptr));

  for (genvar i = 0; i < N; i++) begin : g_thr
    p_quota_r7: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |-> (32'(occ_flat[i*CW +: CW]) < 32'(LIMIT)));

    p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      32'(occ_flat[i*CW +: CW]) <= 32'(LIMIT));

    p_ptr_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |=> (32'(ptr) == 32'((i + 1) % N)));

    for (genvar j = 0; j < N; j++) begin : g_cmp
      p_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[i] && active[j] && !stall[j] && room[j]) |->
        (occ_flat[j*CW +: CW] >= occ_flat[i*CW +: CW]));
    end
  end

endmodule

bind smt_fetch_arbiter smt_fetch_arbiter_chk #(
  .N(N), .CW(CW), .TW(TW), .LIMIT(OCC_LIMIT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .active      (thread_active),
  .stall       (thread_stall),
  .grant       (grant),
  .grant_valid (grant_valid),
  .occ_flat    (occ_flat),
  .ptr         (rr_ptr)
);

// File: tb/smt_fetch_arbiter_test.sv
`timescale 1ns/1ps
module smt_fetch_arbiter_test;
  localparam int N   = 4;
  localparam int DEP = 32;
  localparam int DW  = 4;
  localparam int LIM = DEP / N;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [N-1:0]    act;
  logic [N-1:0]    stl;
  logic [N*DW-1:0] dsp;
  logic [N*DW-1:0] ret;
  logic [N-1:0]    grant;
  logic            gvalid;

  smt_fetch_arbiter #(.NUM_THREADS(N), .QUEUE_DEPTH(DEP), .CNT_DW(DW)) uut (
    .clk (clk), .rst_n (rst_n), .thread_active (act), .thread_stall (stl),
    .disp_cnt (dsp), .retire_cnt (ret), .grant (grant), .grant_valid (gvalid)
  );

  typedef struct { string tag; logic [N-1:0] g; logic v; } exp_t;
  exp_t sb[$];
  event mon_ev;
  int tests = 0;
  int fails = 0;
  int m_occ[N];
  int m_ptr;

  function automatic logic [N*DW-1:0] pk(input int a, input int b, input int c, input int d);
    return {DW'(d), DW'(c), DW'(b), DW'(a)};
  endfunction

  // monitor: pops the expected item and compares with the outputs
  initial forever begin
    exp_t e;
    @(mon_ev);
    e = sb.pop_front();
    tests++;
    if (grant !== e.g || gvalid !== e.v) begin
      fails++;
      $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
               e.tag, grant, gvalid, e.g, e.v);
    end
  end

  // driver: applies one cycle of stimulus, predicts, then advances the model
  task automatic step(input logic [N-1:0] a, input logic [N-1:0] s,
                      input logic [N*DW-1:0] d, input logic [N*DW-1:0] r,
                      input string tag);
    exp_t e;
    int best;
    @(negedge clk);
    act = a; stl = s; dsp = d; ret = r;
    #1;
    best = -1;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (m_ptr + k) % N;
      if (a[idx] && !s[idx] && m_occ[idx] < LIM &&
          (best < 0 || m_occ[idx] < m_occ[best])) best = idx;
    end
    e.tag = tag;
    e.v   = (best >= 0);
    e.g   = (best >= 0) ? (N'(1) << best) : '0;
    sb.push_back(e);
    -> mon_ev;
    #1;
    if (best >= 0) m_ptr = (best + 1) % N;
    for (int t = 0; t < N; t++) begin
      int v;
      v = m_occ[t] + int'(d[t*DW +: DW]);
      v = (int'(r[t*DW +: DW]) >= v) ? 0 : v - int'(r[t*DW +: DW]);
      if (v > LIM) v = LIM;
      m_occ[t] = v;
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  localparam logic [N-1:0] ALL = '1;
  localparam logic [N*DW-1:0] Z = '0;

  initial begin
    rst_n = 1'b0; act = ALL; stl = '0; dsp = '0; ret = '0;
    for (int t = 0; t < N; t++) m_occ[t] = 0;
    m_ptr = 0;
    repeat (3) @(negedge clk);
    #1;
    tests++;
    if (gvalid !== 1'b0 || grant !== '0) begin
      fails++;
      $display("FAIL R1: grant=%b valid=%b during reset expected 0000 0", grant, gvalid);
    end
    @(negedge clk);
    act = '0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 then R5: rotation with equal counts
    step(ALL, '0, Z, Z, "R1 first grant thread 0");
    for (int i = 0; i < 5; i++) step(ALL, '0, Z, Z, "R5 rotation");
    // R3: counts diverge, minimum wins
    step(ALL, '0, pk(3, 0, 2, 0), Z, "R8 dispatch");
    step(ALL, '0, Z, Z, "R3 min count");
    step(ALL, '0, Z, Z, "R3 min count");
    step(ALL, '0, Z, Z, "R3 min count");
    // R2: stalled and inactive threads skipped
    step(ALL, 4'b1010, Z, Z, "R2 stalled skipped");
    step(4'b1011, 4'b0010, Z, Z, "R2 inactive skipped");
    // R8: simultaneous add and remove
    step(ALL, '0, pk(2, 0, 0, 0), pk(2, 0, 0, 0), "R8 same-cycle");
    step(4'b0001, '0, Z, Z, "R8 count unchanged");
    // R6: single thread
    for (int i = 0; i < 4; i++) step(4'b0100, '0, Z, Z, "R6 single thread");
    // R7: fill thread 1 past its share
    step(4'b0000, '0, pk(0, 15, 0, 0), Z, "R8 saturate high");
    step(4'b0010, '0, Z, pk(0, 1, 0, 0), "R7 full thread blocked");
    step(4'b0010, '0, Z, Z, "R7 below limit again");
    step(4'b0010, '0, pk(0, 1, 0, 0), Z, "R7 refill");
    step(4'b0010, '0, Z, Z, "R7 full thread blocked");
    // R8: underflow clamp
    step(4'b0000, '0, Z, pk(0, 0, 0, 15), "R8 saturate low");
    step(ALL, '0, Z, Z, "R8 empty thread wins");
    // R9: nothing eligible, pointer held
    step(ALL, ALL, Z, Z, "R9 all stalled");
    step(4'b0000, '0, Z, Z, "R9 none active");
    step(ALL, '0, Z, pk(15, 15, 15, 15), "R9 pointer kept");
    // R4: ties after draining
    for (int i = 0; i < 6; i++) step(ALL, '0, Z, Z, "R4 tie order");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] a, s;
      logic [N*DW-1:0] d, r;
      a = N'($urandom) | N'(1 << (i % N));
      s = N'($urandom) & N'($urandom);
      d = '0; r = '0;
      for (int t = 0; t < N; t++) begin
        d[t*DW +: DW] = DW'($urandom_range(0, 3));
        r[t*DW +: DW] = DW'($urandom_range(0, 3));
      end
      step(a, s, d, r, "R3 R4 R10 mixed");
    end
    @(negedge clk);
    finish_run();
  end

endmodule